// File: doc/BRIEF.md
# Compact 16-bit Instruction Decoder

This block sits behind the fetch stage of a small 16-bit processor with sixteen general registers. When the front end pulses the decode strobe, the block captures the current instruction word, an interrupt-pending flag and the pending interrupt number. From those held values it produces the decoded fields as pure logic: the instruction class, an operation index, byte/word selection, source and destination register numbers, one addressing-mode code per operand, the value and valid flag of the built-in constant generator, and one "needs an extension word" flag per operand. The fetch unit uses the two flags to decide whether to read zero, one or two extra words.

Source modes on registers 0, 2 and 3 do not behave as ordinary register modes. Register 3 always yields a constant. Register 2 yields absolute addressing or the constants 4 and 8. Register 0 yields symbolic (program-counter relative) or immediate addressing. The decoder resolves all of these cases, so later stages see one flat mode code. Reset leaves a zero word held with the interrupt flag set, so the first thing that is decoded is an interrupt-class entry.

Top module: `insn_decoder`

## Requirements
- R1: `ins_class` is 0 (interrupt) whenever the held interrupt flag is 1. Otherwise it is taken from word bits 15:13: 000 gives 1 (single-operand), 001 gives 2 (jump), and any other value gives 3 (two-operand).
- R2: For single-operand words, `op_idx` = bits 9:7, in the order RRC, SWPB, RRA, SXT, PUSH, CALL, RETI for 0..6. `illegal` is 1 when bits 15:10 differ from 000100 or when bits 9:7 = 7. `illegal` is 0 for every other class.
- R3: For jump words, `op_idx` = bits 12:10, in the order NE, EQ, NC, C, N, GE, L, always for 0..7.
- R4: For two-operand words, `op_idx` = bits 15:12 minus 4, in the order MOV, ADD, ADDC, SUBC, SUB, CMP, DADD, BIT, BIC, BIS, XOR, AND for 0..11. For interrupts, `op_idx` is the held interrupt number.
- R5: `byte_op` equals bit 6 for single- and two-operand words, and is 0 for jumps and interrupts.
- R6: `src_reg` is bits 3:0 for single-operand words and bits 11:8 for two-operand words. `dst_reg` is bits 3:0 for two-operand words only. Both are 0 in all other cases.
- R7: Mode codes are 0 register, 1 indexed, 2 indirect, 3 indirect-autoincrement, 4 symbolic, 5 absolute, 6 immediate, 7 constant. The source mode comes from bits 5:4 (00,01,10,11). On register 0 these give 0,4,2,6. On registers other than 0, 2 and 3 they give 0,1,2,3. The source mode is 0 for jumps and interrupts.
- R8: On register 3, every source mode gives code 7 with `cg_value` 0, 1, 2 or all-ones. On register 2, mode 00 gives 0, 01 gives 5, 10 gives code 7 with value 4, and 11 gives code 7 with value 8. `cg_valid` is 1 exactly when the source mode code is 7, and `cg_value` is 0 whenever `cg_valid` is 0.
- R9: For two-operand words with bit 7 set, the destination mode is 5 on register 2, 4 on register 0 and 1 otherwise. It is 0 in every other case.
- R10: `ext_src` is 1 when the source mode code is 1, 4, 5 or 6. `ext_dst` is 1 when the destination mode code is not 0.
- R11: `is_nop` is 1 exactly for word 0x4303 decoded without an interrupt. `is_nmi` and `is_reset` are 1 for interrupt numbers 14 and 15 respectively, and only in the interrupt class.
- R12: After reset, the held word is 0, the interrupt flag is 1 and the number is 0. The outputs therefore read class 0, `op_idx` 0, and every other output 0.
- R13: While `dec_stb` is low, all outputs keep their values, whatever happens on `insn_in`, `irq_in` and `irq_num_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dec_stb | input | 1 | Capture strobe for word and interrupt inputs |
| insn_in | input | 16 | Instruction word from fetch |
| irq_in | input | 1 | Interrupt pending at decode time |
| irq_num_in | input | 4 | Pending interrupt number |
| ins_class | output | 2 | 0 interrupt, 1 single-operand, 2 jump, 3 two-operand |
| op_idx | output | 4 | Operation index within class, or interrupt number |
| byte_op | output | 1 | Byte-mode operation |
| src_reg | output | 4 | Source register number |
| dst_reg | output | 4 | Destination register number |
| src_mode | output | 3 | Source addressing-mode code |
| dst_mode | output | 3 | Destination addressing-mode code |
| cg_value | output | 16 | Constant-generator value |
| cg_valid | output | 1 | Source operand is a generated constant |
| ext_src | output | 1 | Source needs an extension word |
| ext_dst | output | 1 | Destination needs an extension word |
| illegal | output | 1 | Undefined single-operand encoding |
| is_nop | output | 1 | Word is the canonical no-operation |
| is_nmi | output | 1 | Non-maskable interrupt entry |
| is_reset | output | 1 | Reset vector entry |

## Verification
The corners that are hardest to reach are the register 0, 2 and 3 reinterpretations and the single-operand illegal encodings. Each appears in only a few bit patterns of the 16-bit space, so the stimulus sweeps every possible word with a fresh strobe on each cycle, and each result is compared against a model built from the requirement tables. The interrupt override cannot be seen from the word alone. It is reached by a second sweep of all sixteen interrupt numbers over varied words, and a final phase drops the strobe while changing all inputs, which shows that the held fields do not move.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;

  typedef enum logic [1:0] {
    CLS_IRQ  = 2'd0,
    CLS_ONE  = 2'd1,
    CLS_JMP  = 2'd2,
    CLS_TWO  = 2'd3
  } cls_e;

  typedef enum logic [2:0] {
    AM_REG  = 3'd0,
    AM_IDX  = 3'd1,
    AM_IND  = 3'd2,
    AM_INC  = 3'd3,
    AM_SYM  = 3'd4,
    AM_ABS  = 3'd5,
    AM_IMM  = 3'd6,
    AM_CON  = 3'd7
  } amode_e;

  localparam logic [3:0] REG_PC = 4'd0;
  localparam logic [3:0] REG_SR = 4'd2;
  localparam logic [3:0] REG_CG = 4'd3;

  localparam logic [15:0] NOP_WORD = 16'h4303;

endpackage

// File: rtl/insn_latch.sv
module insn_latch #(
  parameter int WORD_W = 16,
  parameter int NUM_W  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [WORD_W-1:0] word_in,
  input  logic              irq_in,
  input  logic [NUM_W-1:0]  num_in,
  output logic [WORD_W-1:0] word_q,
  output logic              irq_q,
  output logic [NUM_W-1:0]  num_q
);

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  // reset asserts at once, releases after SYNC_STAGES clock edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  logic [WORD_W-1:0] word_d;
  logic              irq_d;
  logic [NUM_W-1:0]  num_d;

  always_comb begin
    word_d = word_q;
    irq_d  = irq_q;
    num_d  = num_q;
    if (stb) begin
      word_d = word_in;
      irq_d  = irq_in;
      num_d  = num_in;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      word_q <= '0;
      irq_q  <= 1'b1;
      num_q  <= '0;
    end else begin
      word_q <= word_d;
      irq_q  <= irq_d;
      num_q  <= num_d;
    end
  end

endmodule

// File: rtl/insn_src_dec.sv
module insn_src_dec
  import insn_dec_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              active,
  input  logic [3:0]        rnum,
  input  logic [1:0]        mbits,
  output amode_e            mode,
  output logic [DATA_W-1:0] cval,
  output logic              cvld,
  output logic              ext
);

  localparam logic [DATA_W-1:0] C_ZERO = DATA_W'(0);
  localparam logic [DATA_W-1:0] C_ONE  = DATA_W'(1);
  localparam logic [DATA_W-1:0] C_TWO  = DATA_W'(2);
  localparam logic [DATA_W-1:0] C_FOUR = DATA_W'(4);
  localparam logic [DATA_W-1:0] C_EIGHT = DATA_W'(8);
  localparam logic [DATA_W-1:0] C_MONE = {DATA_W{1'b1}};

  always_comb begin
    mode = AM_REG;
    cval = C_ZERO;
    if (active) begin
      if (rnum == REG_CG) begin
        mode = AM_CON;
        case (mbits)
          2'b00:   cval = C_ZERO;
          2'b01:   cval = C_ONE;
          2'b10:   cval = C_TWO;
          default: cval = C_MONE;
        endcase
      end else if (rnum == REG_SR) begin
        case (mbits)
          2'b00:   mode = AM_REG;
          2'b01:   mode = AM_ABS;
          2'b10:   begin mode = AM_CON; cval = C_FOUR;  end
          default: begin mode = AM_CON; cval = C_EIGHT; end
        endcase
      end else if (rnum == REG_PC) begin
        case (mbits)
          2'b00:   mode = AM_REG;
          2'b01:   mode = AM_SYM;
          2'b10:   mode = AM_IND;
          default: mode = AM_IMM;
        endcase
      end else begin
        case (mbits)
          2'b00:   mode = AM_REG;
          2'b01:   mode = AM_IDX;
          2'b10:   mode = AM_IND;
          default: mode = AM_INC;
        endcase
      end
    end
  end

  assign cvld = (mode == AM_CON);
  assign ext  = (mode == AM_IDX) || (mode == AM_SYM) ||
                (mode == AM_ABS) || (mode == AM_IMM);

endmodule

// File: rtl/insn_dst_dec.sv
module insn_dst_dec
  import insn_dec_pkg::*;
(
  input  logic       active,
  input  logic [3:0] rnum,
  input  logic       mbit,
  output amode_e     mode,
  output logic       ext
);

  always_comb begin
    mode = AM_REG;
    if (active && mbit) begin
      if (rnum == REG_SR)      mode = AM_ABS;
      else if (rnum == REG_PC) mode = AM_SYM;
      else                     mode = AM_IDX;
    end
  end

  assign ext = (mode != AM_REG);

endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
  import insn_dec_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NUM_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dec_stb,
  input  logic [15:0]       insn_in,
  input  logic              irq_in,
  input  logic [NUM_W-1:0]  irq_num_in,
  output logic [1:0]        ins_class,
  output logic [3:0]        op_idx,
  output logic              byte_op,
  output logic [3:0]        src_reg,
  output logic [3:0]        dst_reg,
  output logic [2:0]        src_mode,
  output logic [2:0]        dst_mode,
  output logic [DATA_W-1:0] cg_value,
  output logic              cg_valid,
  output logic              ext_src,
  output logic              ext_dst,
  output logic              illegal,
  output logic              is_nop,
  output logic              is_nmi,
  output logic              is_reset
);

  localparam int WORD_W = 16;
  localparam logic [NUM_W-1:0] NUM_NMI = NUM_W'(14);
  localparam logic [NUM_W-1:0] NUM_RST = NUM_W'(15);
  localparam logic [5:0] ONE_PREFIX = 6'b000100;

  logic [WORD_W-1:0] w;
  logic              irq_q;
  logic [NUM_W-1:0]  num_q;

  insn_latch #(.WORD_W(WORD_W), .NUM_W(NUM_W), .SYNC_STAGES(2)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (dec_stb),
    .word_in (insn_in),
    .irq_in  (irq_in),
    .num_in  (irq_num_in),
    .word_q  (w),
    .irq_q   (irq_q),
    .num_q   (num_q)
  );

  cls_e cls;
  always_comb begin
    if (irq_q)                 cls = CLS_IRQ;
    else if (w[15:13] == 3'b000) cls = CLS_ONE;
    else if (w[15:13] == 3'b001) cls = CLS_JMP;
    else                       cls = CLS_TWO;
  end

  logic has_src;
  logic has_dst;
  assign has_src = (cls == CLS_ONE) || (cls == CLS_TWO);
  assign has_dst = (cls == CLS_TWO);

  always_comb begin
    op_idx  = 4'd0;
    illegal = 1'b0;
    case (cls)
      CLS_IRQ: op_idx = 4'(num_q);
      CLS_ONE: begin
        op_idx  = {1'b0, w[9:7]};
        illegal = (w[15:10] != ONE_PREFIX) || (w[9:7] == 3'b111);
      end
      CLS_JMP: op_idx = {1'b0, w[12:10]};
      default: op_idx = w[15:12] - 4'd4;
    endcase
  end

  assign byte_op = has_src & w[6];
  assign src_reg = (cls == CLS_ONE) ? w[3:0] : (has_dst ? w[11:8] : 4'd0);
  assign dst_reg = has_dst ? w[3:0] : 4'd0;

  amode_e smode;
  amode_e dmode;

  insn_src_dec #(.DATA_W(DATA_W)) u_src (
    .active (has_src),
    .rnum   (src_reg),
    .mbits  (w[5:4]),
    .mode   (smode),
    .cval   (cg_value),
    .cvld   (cg_valid),
    .ext    (ext_src)
  );

  insn_dst_dec u_dst (
    .active (has_dst),
    .rnum   (dst_reg),
    .mbit   (w[7]),
    .mode   (dmode),
    .ext    (ext_dst)
  );

  assign ins_class = cls;
  assign src_mode  = smode;
  assign dst_mode  = dmode;
  assign is_nop    = !irq_q && (w == NOP_WORD);
  assign is_nmi    = irq_q && (num_q == NUM_NMI);
  assign is_reset  = irq_q && (num_q == NUM_RST);

endmodule

// File: rtl/insn_decoder_chk.sv
module insn_decoder_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dec_stb,
  input logic [1:0]        ins_class,
  input logic [3:0]        op_idx,
  input logic              byte_op,
  input logic [3:0]        src_reg,
  input logic [3:0]        dst_reg,
  input logic [2:0]        src_mode,
  input logic [2:0]        dst_mode,
  input logic [DATA_W-1:0] cg_value,
  input logic              cg_valid,
  input logic              ext_src,
  input logic              ext_dst,
  input logic              illegal,
  input logic              is_nop,
  input logic              is_nmi,
  input logic              is_reset
);

  AST_NONOP_CLASS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_class == 2'd0 || ins_class == 2'd2) |-> (!byte_op && !cg_valid && src_mode == 3'd0 && !ext_src && !ext_dst)); // R5

  AST_CONST_FLAG_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    cg_valid == (src_mode == 3'd7)); // R8

  AST_CONST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cg_valid |-> (cg_value == '0)); // R8

  AST_EXT_SRC_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    ext_src == (src_mode == 3'd1 || src_mode == 3'd4 || src_mode == 3'd5 || src_mode == 3'd6)); // R10

  AST_DST_ONLY_TWO: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_class != 2'd3) |-> (dst_mode == 3'd0 && dst_reg == 4'd0)); // R9

  AST_NOP_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    is_nop |-> (ins_class == 2'd3 && op_idx == 4'd0 && cg_valid && cg_value == '0)); // R11

  AST_VECTOR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (is_nmi || is_reset) |-> ($onehot0({is_nmi, is_reset}) && ins_class == 2'd0)); // R11

  AST_ILLEGAL_ONE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (ins_class == 2'd1)); // R2

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_stb |=> ($stable(ins_class) && $stable(op_idx) && $stable(src_mode) &&
                  $stable(dst_mode) && $stable(cg_value) && $stable(src_reg))); // R13

endmodule

bind insn_decoder insn_decoder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dec_stb   (dec_stb),
  .ins_class (ins_class),
  .op_idx    (op_idx),
  .byte_op   (byte_op),
  .src_reg   (src_reg),
  .dst_reg   (dst_reg),
  .src_mode  (src_mode),
  .dst_mode  (dst_mode),
  .cg_value  (cg_value),
  .cg_valid  (cg_valid),
  .ext_src   (ext_src),
  .ext_dst   (ext_dst),
  .illegal   (illegal),
  .is_nop    (is_nop),
  .is_nmi    (is_nmi),
  .is_reset  (is_reset)
);

// File: tb/insn_decoder_tb.sv
module insn_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 190000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        dec_stb;
  logic [15:0] insn_in;
  logic        irq_in;
  logic [3:0]  irq_num_in;
  logic [1:0]  ins_class;
  logic [3:0]  op_idx;
  logic        byte_op;
  logic [3:0]  src_reg;
  logic [3:0]  dst_reg;
  logic [2:0]  src_mode;
  logic [2:0]  dst_mode;
  logic [15:0] cg_value;
  logic        cg_valid;
  logic        ext_src;
  logic        ext_dst;
  logic        illegal;
  logic        is_nop;
  logic        is_nmi;
  logic        is_reset;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  insn_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .dec_stb(dec_stb), .insn_in(insn_in),
    .irq_in(irq_in), .irq_num_in(irq_num_in), .ins_class(ins_class),
    .op_idx(op_idx), .byte_op(byte_op), .src_reg(src_reg), .dst_reg(dst_reg),
    .src_mode(src_mode), .dst_mode(dst_mode), .cg_value(cg_value),
    .cg_valid(cg_valid), .ext_src(ext_src), .ext_dst(ext_dst),
    .illegal(illegal), .is_nop(is_nop), .is_nmi(is_nmi), .is_reset(is_reset)
  );

  task automatic chk(input string req, input string what, input int got, input int exp, input int word);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s word=%04h got=%0h exp=%0h", req, what, word, got, exp);
    end
  endtask

  // reference model built from the requirement tables
  task automatic expect_word(input logic [15:0] w, input logic irq, input logic [3:0] num);
    int cls, op, bop, sr, dr, sm, dm, cv, cvl, es, ed, ill, nop, nmi, rst;
    bit hs, hd;
    cls = irq ? 0 : (w[15:13] == 3'b000) ? 1 : (w[15:13] == 3'b001) ? 2 : 3;
    hs = (cls == 1) || (cls == 3);
    hd = (cls == 3);
    ill = 0;
    case (cls)
      0: op = num;
      1: begin op = w[9:7]; ill = (w[15:10] != 6'b000100 || w[9:7] == 3'd7) ? 1 : 0; end
      2: op = w[12:10];
      default: op = int'(w[15:12]) - 4;
    endcase
    bop = hs ? w[6] : 0;
    sr = (cls == 1) ? w[3:0] : hd ? w[11:8] : 0;
    dr = hd ? w[3:0] : 0;
    sm = 0; cv = 0;
    if (hs) begin
      if (sr == 3) begin
        sm = 7;
        cv = (w[5:4] == 0) ? 0 : (w[5:4] == 1) ? 1 : (w[5:4] == 2) ? 2 : 16'hFFFF;
      end else if (sr == 2) begin
        sm = (w[5:4] == 0) ? 0 : (w[5:4] == 1) ? 5 : 7;
        cv = (w[5:4] == 2) ? 4 : (w[5:4] == 3) ? 8 : 0;
      end else if (sr == 0) begin
        sm = (w[5:4] == 0) ? 0 : (w[5:4] == 1) ? 4 : (w[5:4] == 2) ? 2 : 6;
      end else begin
        sm = w[5:4];
      end
    end
    cvl = (sm == 7) ? 1 : 0;
    dm = 0;
    if (hd && w[7]) dm = (dr == 2) ? 5 : (dr == 0) ? 4 : 1;
    es = (sm == 1 || sm == 4 || sm == 5 || sm == 6) ? 1 : 0;
    ed = (dm != 0) ? 1 : 0;
    nop = (!irq && w == 16'h4303) ? 1 : 0;
    nmi = (irq && num == 4'd14) ? 1 : 0;
    rst = (irq && num == 4'd15) ? 1 : 0;

    chk("R1", "class", ins_class, cls, w);
    chk((cls == 1) ? "R2" : (cls == 2) ? "R3" : "R4", "op_idx", op_idx, op, w);
    chk("R2", "illegal", illegal, ill, w);
    chk("R5", "byte_op", byte_op, bop, w);
    chk("R6", "src_reg", src_reg, sr, w);
    chk("R6", "dst_reg", dst_reg, dr, w);
    chk("R7", "src_mode", src_mode, sm, w);
    chk("R8", "cg_value", cg_value, cv, w);
    chk("R8", "cg_valid", cg_valid, cvl, w);
    chk("R9", "dst_mode", dst_mode, dm, w);
    chk("R10", "ext_src", ext_src, es, w);
    chk("R10", "ext_dst", ext_dst, ed, w);
    chk("R11", "is_nop", is_nop, nop, w);
    chk("R11", "is_nmi", is_nmi, nmi, w);
    chk("R11", "is_reset", is_reset, rst, w);
  endtask

  task automatic apply(input logic [15:0] w, input logic irq, input logic [3:0] num);
    insn_in    = w;
    irq_in     = irq;
    irq_num_in = num;
    dec_stb    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    expect_word(w, irq, num);
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; dec_stb = 1'b0; insn_in = 16'hFFFF; irq_in = 1'b0; irq_num_in = 4'd9;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R12: reset contents decode as interrupt 0 with word 0
    chk("R12", "reset class", ins_class, 0, 0);
    chk("R12", "reset op_idx", op_idx, 0, 0);
    expect_word(16'h0000, 1'b1, 4'd0);

    // R1..R11: every word without interrupt
    for (int i = 0; i < 65536; i++) apply(16'(i), 1'b0, 4'd0);

    // R1 override, R4 interrupt index, R11 vectors
    for (int n = 0; n < 16; n++) begin
      apply(16'h4303, 1'b1, 4'(n));
      apply(16'(16'h1234 * (n + 1)), 1'b1, 4'(n));
    end

    // R13: strobe low, inputs change, outputs hold on a two-operand word
    apply(16'h5A37, 1'b0, 4'd0);
    dec_stb = 1'b0;
    for (int k = 0; k < 8; k++) begin
      insn_in = 16'(16'h0F0F ^ (k * 16'h1111));
      irq_in = k[0];
      irq_num_in = 4'(k + 8);
      @(posedge clk);
      @(negedge clk);
      expect_word(16'h5A37, 1'b0, 4'd0); // R13
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule